// File: doc/BRIEF.md
# UART Fractional Baud Tick Generator

This block turns a fast reference clock into the two timing strobes a UART needs: a sample strobe at the oversampling rate and a bit strobe once per serial bit. Three stages run in series. A prescaler divides the clock by an integer part plus a fractional part in eighths, spreading the fraction by stretching some periods by one cycle. A 16-bit divisor then counts prescaler ticks, and a last stage counts sample strobes to mark the end of each bit.

The prescaler can be bypassed, so that the divisor counts every clock. With an 18.432 MHz reference, a prescale of 10 and a zero fraction give the 1.8432 MHz rate that the classic divisor values expect. The usual rates up to 115200 baud then follow. The samples-per-bit count can be set between 4 and 16, and is not fixed at 16.

A change to the prescale byte or either divisor byte restarts every counter. Both strobes are one clock wide. They are decoded from internal state and the current configuration inputs, so a strobe is seen in the same cycle as the state that produces it.

Top module: `uart_baud_ticker`

## Requirements
- R1: With `prescale_on`=1, the prescale byte gives M=`prescale_cfg[7:3]` and N=`prescale_cfg[2:0]`. After a restart, the k-th prescaler tick comes exactly M·k + floor(N·k/8) clocks after the restart cycle. Each period therefore lasts M or M+1 clocks, and a 3-bit fraction accumulator that starts at zero decides which.
- R2: With `prescale_on`=0, the prescaler ticks on every active clock. An M of 0 acts as 1. Leaving bypass starts a fresh prescaler period with the accumulator at zero.
- R3: The divisor D={`div_hi`,`div_lo`} (high byte in bits 15:8). `samp_tick` fires on every D-th prescaler tick and coincides with that tick. A D of 0 acts as 1.
- R4: S is 16 when `samp_cfg` is 0, 1, 2 or 3, and S equals `samp_cfg` for values 4 to 15. `bit_tick` fires together with every S-th `samp_tick`. A change of `samp_cfg` does not restart any counter.
- R5: In the first cycle in which `prescale_cfg`, `div_lo` or `div_hi` differs from its value in the cycle before, both strobes are low. All counters and the accumulator then restart from zero, so that cycle acts as the restart cycle of R1.
- R6: While `rst_n` is low both strobes are low. They stay low for the first two clock edges after `rst_n` rises. The first active cycle compares the configuration with all-zero values.
- R7: With M=10, N=0, D=1 and S=16, `samp_tick` fires on every 10th clock after the restart cycle, and `bit_tick` fires on every 160th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prescale_cfg | input | 8 | Prescale integer [7:3] and eighths fraction [2:0] |
| prescale_on | input | 1 | 1 applies the prescaler, 0 bypasses it |
| samp_cfg | input | 4 | Samples-per-bit code |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| samp_tick | output | 1 | One-clock oversampling strobe |
| bit_tick | output | 1 | One-clock bit strobe |

## Verification
Both strobes are combinational functions of registered state and the present inputs. A configuration change therefore shows in the same cycle: strobes are low in that cycle, and the first prescaler tick follows M clocks later. A reset release delays activity by exactly two edges. The bench changes inputs just after a rising edge, compares against its arithmetic reference on the following falling edge, and advances the reference there. Every check therefore falls in the cycle whose state the design has just registered.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Smallest programmable samples-per-bit value; codes below it select the maximum.
  localparam int unsigned BT_MIN_SPB = 4;

  typedef enum logic {
    PRE_BYPASS = 1'b0,
    PRE_ACTIVE = 1'b1
  } pre_mode_e;
endpackage

// File: rtl/bt_cfg_watch.sv
// Registers a configuration word and flags the first cycle it differs.
module bt_cfg_watch #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg,
  output logic         changed
);
  logic [W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d   = cfg;
    changed = (cfg != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R5: a flagged change is absorbed by the next edge
  p_change_absorbed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (cfg_q == $past(cfg)));
endmodule

// File: rtl/bt_prescaler.sv
// Fractional prescaler: period of M or M+1 clocks chosen by an eighths accumulator.
module bt_prescaler
  import bt_pkg::*;
#(
  parameter int unsigned INT_W  = 5,
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet,
  input  pre_mode_e         mode,
  input  logic [INT_W-1:0]  m_in,
  input  logic [FRAC_W-1:0] n_in,
  output logic              pre_tick
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  pcnt_q, pcnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  m_eff, len, len_m1;
  logic [FRAC_W:0]   frac_sum;
  logic              carry, hit;

  always_comb begin
    m_eff    = (m_in == '0) ? CNT_W'(1) : {1'b0, m_in};
    frac_sum = {1'b0, acc_q} + {1'b0, n_in};
    carry    = frac_sum[FRAC_W];
    len      = m_eff + CNT_W'(carry);
    len_m1   = len - CNT_W'(1);
    hit      = (pcnt_q == len_m1);
    pre_tick = !quiet && ((mode == PRE_BYPASS) || hit);

    if (quiet || (mode == PRE_BYPASS)) begin
      pcnt_d = '0;
      acc_d  = '0;
    end else if (hit) begin
      pcnt_d = '0;
      acc_d  = frac_sum[FRAC_W-1:0];
    end else begin
      pcnt_d = pcnt_q + CNT_W'(1);
      acc_d  = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      acc_q  <= acc_d;
    end
  end

  // R2: bypass ticks on every active cycle
  p_bypass_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PRE_BYPASS) && !quiet) |-> pre_tick);
  // R2: bypass leaves the period counter cleared
  p_bypass_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PRE_BYPASS) |=> (pcnt_q == '0) && (acc_q == '0));
  // R1: back-to-back ticks while active only when the period is one clock
  p_min_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && $past(pre_tick) && (mode == PRE_ACTIVE)) |-> (m_eff == CNT_W'(1)));
  // R1: the fraction accumulator moves only on a period end
  p_acc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PRE_ACTIVE) && !quiet && !pre_tick) |=> $stable(acc_q));
endmodule

// File: rtl/bt_stage_counter.sv
// Counts step strobes and flags the one that completes a group of last+1.
module bt_stage_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit = step && !clr && (cnt_q >= last);
    if (clr)       cnt_d = '0;
    else if (hit)  cnt_d = '0;
    else if (step) cnt_d = cnt_q + W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: without a step the count is frozen
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));
  // R5: a clear leaves the count at zero
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/uart_baud_ticker.sv
module uart_baud_ticker
  import bt_pkg::*;
#(
  parameter int unsigned INT_W  = 5,
  parameter int unsigned FRAC_W = 3,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SPB_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INT_W+FRAC_W-1:0]   prescale_cfg,
  input  logic                      prescale_on,
  input  logic [SPB_W-1:0]          samp_cfg,
  input  logic [BYTE_W-1:0]         div_lo,
  input  logic [BYTE_W-1:0]         div_hi,
  output logic                      samp_tick,
  output logic                      bit_tick
);
  localparam int unsigned CPR_W   = INT_W + FRAC_W;
  localparam int unsigned DIV_W   = 2 * BYTE_W;
  localparam int unsigned WATCH_W = CPR_W + DIV_W;

  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic               cfg_changed, quiet, pre_tick;
  logic [DIV_W-1:0]   div_val, div_last;
  logic [SPB_W-1:0]   spb_last;
  pre_mode_e          mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_comb begin
    div_val  = {div_hi, div_lo};
    div_last = (div_val == '0) ? '0 : (div_val - DIV_W'(1));
    spb_last = (samp_cfg < SPB_W'(BT_MIN_SPB)) ? '1 : (samp_cfg - SPB_W'(1));
    mode     = prescale_on ? PRE_ACTIVE : PRE_BYPASS;
    quiet    = cfg_changed || !rst_i_n;
  end

  bt_cfg_watch #(.W(WATCH_W)) u_watch (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cfg     ({prescale_cfg, div_hi, div_lo}),
    .changed (cfg_changed)
  );

  bt_prescaler #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .quiet    (quiet),
    .mode     (mode),
    .m_in     (prescale_cfg[CPR_W-1:FRAC_W]),
    .n_in     (prescale_cfg[FRAC_W-1:0]),
    .pre_tick (pre_tick)
  );

  bt_stage_counter #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (quiet),
    .step  (pre_tick),
    .last  (div_last),
    .hit   (samp_tick)
  );

  bt_stage_counter #(.W(SPB_W)) u_spb (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (quiet),
    .step  (samp_tick),
    .last  (spb_last),
    .hit   (bit_tick)
  );

  // R6: no strobe while the internal reset is held
  p_reset_quiet_r6: assert property (@(posedge clk)
    !rst_i_n |-> (!samp_tick && !bit_tick));
  // R5: the change cycle carries no strobe
  p_restart_quiet_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    cfg_changed |-> (!samp_tick && !bit_tick));
  // R3: divisor of 0 or 1 passes every prescaler tick
  p_div_unity_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (div_val <= DIV_W'(1)) |-> (samp_tick == pre_tick));
  // R4: a bit strobe always rides on a sample strobe
  p_bit_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    bit_tick |-> (samp_tick && pre_tick));
endmodule

// File: tb/uart_baud_ticker_tb.sv
module uart_baud_ticker_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] prescale_cfg;
  logic       prescale_on;
  logic [3:0] samp_cfg;
  logic [7:0] div_lo, div_hi;
  logic       samp_tick, bit_tick;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R6";

  // reference state
  int sync_cnt = 0;
  int c_since = 0;
  int k_next = 1;
  int d_pos = 0;
  int s_pos = 0;
  int cpr_seen = 0;
  int div_seen = 0;

  always #5 clk = ~clk;

  uart_baud_ticker u_dut (
    .clk(clk), .rst_n(rst_n), .prescale_cfg(prescale_cfg),
    .prescale_on(prescale_on), .samp_cfg(samp_cfg),
    .div_lo(div_lo), .div_hi(div_hi),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // arithmetic reference, evaluated and advanced on every falling edge
  always @(negedge clk) begin
    int m, n, d, s, divv;
    bit pre, samp, bitt;
    pre = 0; samp = 0; bitt = 0;
    if (!rst_n) begin
      sync_cnt = 0; c_since = 0; k_next = 1; d_pos = 0; s_pos = 0;
      cpr_seen = 0; div_seen = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      divv = {div_hi, div_lo};
      if (int'(prescale_cfg) != cpr_seen || divv != div_seen) begin
        cpr_seen = prescale_cfg; div_seen = divv;
        c_since = 0; k_next = 1; d_pos = 0; s_pos = 0;
      end else begin
        m = prescale_cfg[7:3]; if (m == 0) m = 1;
        n = prescale_cfg[2:0];
        d = (divv == 0) ? 1 : divv;
        s = (samp_cfg < 4) ? 16 : int'(samp_cfg);
        if (!prescale_on) begin
          pre = 1; c_since = 0; k_next = 1;
        end else begin
          c_since++;
          if (c_since == k_next * m + (k_next * n) / 8) begin
            pre = 1; k_next++;
          end
        end
        if (pre) begin
          d_pos++;
          if (d_pos >= d) begin samp = 1; d_pos = 0; end
        end
        if (samp) begin
          s_pos++;
          if (s_pos >= s) begin bitt = 1; s_pos = 0; end
        end
      end
    end
    check(samp_tick === samp, {cur_tag, " samp_tick"}, samp_tick, samp);
    check(bit_tick === bitt, {cur_tag, " bit_tick"}, bit_tick, bitt);
  end

  task automatic drive(input logic [7:0] cpr, input logic on, input logic [3:0] tcr,
                       input logic [7:0] lo, input logic [7:0] hi);
    @(posedge clk); #1;
    prescale_cfg = cpr; prescale_on = on; samp_cfg = tcr; div_lo = lo; div_hi = hi;
  endtask

  task automatic count_ticks(input int ncyc, output int ns, output int nb);
    ns = 0; nb = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk); #1;
      ns += int'(samp_tick); nb += int'(bit_tick);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ns, nb;
    rst_n = 1'b0; prescale_cfg = 8'h00; prescale_on = 1'b0; samp_cfg = 4'd0;
    div_lo = 8'h00; div_hi = 8'h00;
    cur_tag = "R6";
    repeat (4) @(negedge clk);
    check(samp_tick == 0 && bit_tick == 0, "R6 reset outputs", samp_tick, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1 check(samp_tick == 0, "R6 first edge", samp_tick, 0);
    @(negedge clk); #1 check(samp_tick == 0, "R6 second edge", samp_tick, 0);
    @(negedge clk); #1 check(samp_tick == 1, "R2 R3 bypass div0 active", samp_tick, 1);
    cur_tag = "R2 R3 R4";
    repeat (40) @(posedge clk);

    // bypass, divisor 3, four samples per bit
    drive(8'h00, 1'b0, 4'd4, 8'd3, 8'd0);
    repeat (120) @(posedge clk);

    // R7: nominal 10x prescale
    cur_tag = "R7";
    drive(8'h50, 1'b1, 4'd0, 8'd1, 8'd0);
    count_ticks(200, ns, nb);
    check(ns == 19, "R7 samples in 200 cycles", ns, 19);
    check(nb == 1, "R7 bits in 200 cycles", nb, 1);

    // R1: fractional 3 + 5/8
    cur_tag = "R1";
    drive({5'd3, 3'd5}, 1'b1, 4'd5, 8'd2, 8'd0);
    count_ticks(117, ns, nb);
    // ticks k with 3k+floor(5k/8)<=116 -> k<=32 -> 16 samples, 3 bits
    check(ns == 16, "R1 samples in 116 active cycles", ns, 16);
    check(nb == 3, "R1 bits in 116 active cycles", nb, 3);
    repeat (300) @(posedge clk);

    // R1 R3: M=1 N=7 with high divisor byte
    cur_tag = "R1 R3";
    drive({5'd1, 3'd7}, 1'b1, 4'd4, 8'd0, 8'd1);
    repeat (2500) @(posedge clk);

    // R2: M of zero acts as one, toggling the bypass
    cur_tag = "R2";
    drive({5'd0, 3'd0}, 1'b1, 4'd4, 8'd1, 8'd0);
    count_ticks(33, ns, nb);
    check(ns == 32, "R2 M zero as one", ns, 32);
    drive({5'd0, 3'd0}, 1'b0, 4'd4, 8'd1, 8'd0);
    repeat (10) @(posedge clk);
    drive({5'd0, 3'd0}, 1'b1, 4'd4, 8'd1, 8'd0);
    repeat (20) @(posedge clk);

    // R4: samples-per-bit codes
    cur_tag = "R4";
    drive(8'h00, 1'b0, 4'd1, 8'd1, 8'd0);
    count_ticks(33, ns, nb);
    check(nb == 2, "R4 code 1 acts as 16", nb, 2);
    drive(8'h00, 1'b0, 4'd15, 8'd0, 8'd0);
    count_ticks(33, ns, nb);
    check(nb == 2, "R4 code 15", nb, 2);
    drive(8'h00, 1'b0, 4'd4, 8'd1, 8'd0);
    count_ticks(33, ns, nb);
    check(nb == 8, "R4 code 4", nb, 8);
    drive(8'h00, 1'b0, 4'd6, 8'd1, 8'd0);
    repeat (40) @(posedge clk);

    // R5: change of divisor mid-run restarts everything
    cur_tag = "R5";
    drive({5'd2, 3'd0}, 1'b1, 4'd4, 8'd3, 8'd0);
    repeat (37) @(posedge clk);
    drive({5'd2, 3'd0}, 1'b1, 4'd4, 8'd4, 8'd0);
    count_ticks(1, ns, nb);
    check(ns == 0 && nb == 0, "R5 change cycle quiet", ns, 0);
    count_ticks(8, ns, nb);
    check(ns == 1, "R5 first sample after restart", ns, 1);
    drive({5'd4, 3'd0}, 1'b1, 4'd4, 8'd4, 8'd0);
    repeat (60) @(posedge clk);

    // R6: mid-run reset
    cur_tag = "R6";
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk); #1 check(samp_tick == 0 && bit_tick == 0, "R6 mid-run reset", samp_tick, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (30) @(posedge clk);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule